// File: doc/BRIEF.md
# Staged Clock Divider Update Controller

This block holds one integer divide ratio for each of several clock domains. Software writes new ratios into staging registers ahead of time, and these writes leave the running dividers alone. A ratio moves into its live divider only when software sets the matching bit in one shared commit register. Each domain moves over on its own, so software can stage any mix of new ratios and then release them one at a time or together.

After a commit bit is set, the domain raises a busy flag. The live divider picks up the new ratio at its next terminal count, so the running period is never cut short. Busy then drops and the commit bit clears itself. Software learns that the change is complete by polling the busy bits. Each domain is modelled as a counter-based divider whose output is a one-cycle tick at the divided rate.

Top module: `clkdiv_stage_ctrl`

## Requirements
- R1: After reset every live ratio and every staging register holds 1, and all commit bits and busy flags read 0.
- R2: A write to a staging register leaves the live ratio of that domain unchanged until that domain is committed.
- R3: Address map: addresses 0..NUM_DOM-1 are the staging registers (ratio in bits DIV_W-1:0). Address NUM_DOM is the commit register: writing a 1 in bit i sets commit bit i, writing 0 bits has no effect, and a read returns the commit bits. Address NUM_DOM+1 reads the busy flags, and writes to it are ignored.
- R4: A domain's busy flag goes high in the cycle after its commit bit is set.
- R5: While busy, the live ratio takes the staged value captured at the commit write at the first terminal count of the running divider. Busy falls on that same edge.
- R6: A captured staged value of 0 becomes a live ratio of 1.
- R7: The commit bit clears on the edge where busy falls.
- R8: A staging write, or a new commit bit, arriving while the domain's commit is in progress does not change that commit. The new staged value takes effect only through a later commit.
- R9: One commit write with several bits set updates each of those domains, and the other domains stay idle and unchanged.
- R10: With live ratio L, the domain's tick output pulses exactly once every L clock cycles.
- R11: A read of a staging register returns the value last written to it, including 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational by default) |
| live_div | output | NUM_DOM*DIV_W | Live ratio of each domain, domain i in slice i |
| div_busy | output | NUM_DOM | Per-domain commit-in-progress flag |
| div_tick | output | NUM_DOM | Per-domain divided tick, one cycle wide |

## Verification
A commit bit can be read back in the cycle after the write edge. Busy is due one cycle later. The live ratio follows within one full period of the old ratio. The bench drives each write on a falling edge, reads the commit bit at the next falling edge, and checks busy at the falling edge after that. It then polls busy once per cycle, with a bound set by the old ratio, before it compares the live ratio, the cleared commit bit and the tick count over a whole number of periods. Staging reads are combinational and are sampled 1 ns after the address settles.

// File: rtl/cds_pkg.sv
package cds_pkg;
   typedef enum logic [1:0] {
      CDS_SEL_STAGE,
      CDS_SEL_SEQ,
      CDS_SEL_BUSY,
      CDS_SEL_NONE
   } cds_sel_e;
endpackage

// File: rtl/cds_regfile.sv
module cds_regfile
   import cds_pkg::*;
#(
   parameter int NUM_DOM  = 4,
   parameter int DIV_W    = 8,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 3,
   parameter bit READ_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_DOM-1:0]       en_q,
   input  logic [NUM_DOM-1:0]       busy_q,
   output logic [NUM_DOM*DIV_W-1:0] staged_flat,
   output logic [NUM_DOM-1:0]       set_req,
   output logic [DATA_W-1:0]        rdata
);
   localparam int SEQ_ADDR  = NUM_DOM;
   localparam int BUSY_ADDR = NUM_DOM + 1;

   cds_sel_e          sel;
   logic              seq_hit;
   logic [DATA_W-1:0] rd_next;

   assign seq_hit = wr_en && (addr == ADDR_W'(SEQ_ADDR));
   assign set_req = seq_hit ? wdata[NUM_DOM-1:0] : '0;

   generate
      for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_stage
         logic [DIV_W-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               stage_q <= DIV_W'(1);
            else if (wr_en && addr == ADDR_W'(gi))
               stage_q <= wdata[DIV_W-1:0];
         end
         assign staged_flat[gi*DIV_W +: DIV_W] = stage_q;

         a_r11_stage_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(gi)) |=> (stage_q == $past(wdata[DIV_W-1:0])));
      end
   endgenerate

   always_comb begin
      if (int'(addr) < NUM_DOM)        sel = CDS_SEL_STAGE;
      else if (int'(addr) == SEQ_ADDR)  sel = CDS_SEL_SEQ;
      else if (int'(addr) == BUSY_ADDR) sel = CDS_SEL_BUSY;
      else                              sel = CDS_SEL_NONE;
   end

   always_comb begin
      rd_next = '0;
      unique case (sel)
         CDS_SEL_STAGE: begin
            for (int i = 0; i < NUM_DOM; i++)
               if (addr == ADDR_W'(i))
                  rd_next = DATA_W'(staged_flat[i*DIV_W +: DIV_W]);
         end
         CDS_SEL_SEQ:  rd_next = DATA_W'(en_q);
         CDS_SEL_BUSY: rd_next = DATA_W'(busy_q);
         default:      rd_next = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign rdata = rd_next;
      end
   endgenerate
endmodule

// File: rtl/cds_commit.sv
module cds_commit #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_req,
   input  logic [DIV_W-1:0] staged,
   input  logic             tick,
   output logic             en_q,
   output logic             busy_q,
   output logic [DIV_W-1:0] live
);
   logic [DIV_W-1:0] pend_q;
   logic [DIV_W-1:0] staged_fix;

   assign staged_fix = (staged == '0) ? DIV_W'(1) : staged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         busy_q <= 1'b0;
         pend_q <= DIV_W'(1);
         live   <= DIV_W'(1);
      end else begin
         if (set_req && !en_q) begin
            en_q   <= 1'b1;
            pend_q <= staged_fix;
         end
         if (en_q && !busy_q)
            busy_q <= 1'b1;
         if (busy_q && tick) begin
            live   <= pend_q;
            busy_q <= 1'b0;
            en_q   <= 1'b0;
         end
      end
   end

   a_r4_busy_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |=> busy_q);
   a_r5_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && tick) |=> $stable(live));
   a_r6_live_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      live != '0);
   a_r7_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !en_q);
   a_r3_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> en_q);
endmodule

// File: rtl/cds_divcnt.sv
module cds_divcnt #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] live,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q >= live - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + DIV_W'(1);
   end

   a_r10_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < live);
endmodule

// File: rtl/clkdiv_stage_ctrl.sv
module clkdiv_stage_ctrl #(
   parameter int NUM_DOM  = 4,
   parameter int DIV_W    = 8,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 3,
   parameter bit READ_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic [NUM_DOM*DIV_W-1:0] live_div,
   output logic [NUM_DOM-1:0]       div_busy,
   output logic [NUM_DOM-1:0]       div_tick
);
   localparam int MAP_SIZE = NUM_DOM + 2;

   generate
      if (MAP_SIZE > (1 << ADDR_W)) begin : g_chk_addr
         $error("ADDR_W too small for the register map");
      end
      if (DATA_W < DIV_W || DATA_W < NUM_DOM) begin : g_chk_data
         $error("DATA_W must hold a ratio and all commit bits");
      end
      if (DIV_W < 1 || NUM_DOM < 1) begin : g_chk_min
         $error("DIV_W and NUM_DOM must be at least 1");
      end
   endgenerate

   logic [NUM_DOM*DIV_W-1:0] staged_flat;
   logic [NUM_DOM-1:0]       set_req;
   logic [NUM_DOM-1:0]       en_vec;

   cds_regfile #(
      .NUM_DOM (NUM_DOM),
      .DIV_W   (DIV_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .READ_REG(READ_REG)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .en_q       (en_vec),
      .busy_q     (div_busy),
      .staged_flat(staged_flat),
      .set_req    (set_req),
      .rdata      (reg_rdata)
   );

   generate
      for (genvar gd = 0; gd < NUM_DOM; gd++) begin : g_dom
         cds_commit #(.DIV_W(DIV_W)) u_commit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_req(set_req[gd]),
            .staged (staged_flat[gd*DIV_W +: DIV_W]),
            .tick   (div_tick[gd]),
            .en_q   (en_vec[gd]),
            .busy_q (div_busy[gd]),
            .live   (live_div[gd*DIV_W +: DIV_W])
         );
         cds_divcnt #(.DIV_W(DIV_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .live (live_div[gd*DIV_W +: DIV_W]),
            .tick (div_tick[gd])
         );
      end
   endgenerate

   a_r9_busy_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (div_busy & ~en_vec) == '0);
endmodule

// File: tb/clkdiv_stage_ctrl_bench.sv
module clkdiv_stage_ctrl_bench;
   localparam int ND = 4, DW = 8, XW = 16, AW = 3;
   localparam int SEQ_A = ND, BUSY_A = ND + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [XW-1:0] reg_wdata = '0;
   logic [XW-1:0] reg_rdata;
   logic [ND*DW-1:0] live_div;
   logic [ND-1:0] div_busy, div_tick;

   always #2 clk = ~clk;

   clkdiv_stage_ctrl u_clkdiv_stage_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .live_div(live_div),
      .div_busy(div_busy), .div_tick(div_tick));

   int checks = 0, fails = 0;
   logic [DW-1:0] m_stage [ND];
   logic [DW-1:0] m_live  [ND];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] sanit(logic [DW-1:0] v);
      return (v == '0) ? DW'(1) : v;
   endfunction

   function automatic logic [DW-1:0] live_of(int d);
      return live_div[d*DW +: DW];
   endfunction

   task automatic wr(int a, logic [XW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(int a, output logic [XW-1:0] v);
      reg_addr = AW'(a);
      #1;
      v = reg_rdata;
   endtask

   task automatic stage(int d, logic [DW-1:0] v);
      wr(d, XW'(v));
      m_stage[d] = v;
   endtask

   task automatic wait_idle(int d, int limit, string req);
      int n = 0;
      while (div_busy[d] && n < limit) begin
         @(negedge clk);
         n++;
      end
      chk(req, 32'(div_busy[d]), 0);
   endtask

   task automatic commit(logic [ND-1:0] mask);
      logic [DW-1:0] snap [ND];
      logic [DW-1:0] old  [ND];
      logic [XW-1:0] v;
      for (int d = 0; d < ND; d++) begin
         snap[d] = m_stage[d];
         old[d]  = m_live[d];
      end
      wr(SEQ_A, XW'(mask));
      rd(SEQ_A, v);
      chk("R3 commit bits set", 32'(v[ND-1:0] & mask), 32'(mask));
      @(negedge clk);
      for (int d = 0; d < ND; d++)
         if (mask[d]) chk("R4 busy next cycle", 32'(div_busy[d]), 1);
         else         chk("R9 unselected idle", 32'(div_busy[d]), 0);
      for (int d = 0; d < ND; d++)
         if (mask[d]) begin
            wait_idle(d, int'(old[d]) + 2, "R5 busy bounded by old period");
            m_live[d] = sanit(snap[d]);
         end
      rd(SEQ_A, v);
      chk("R7 commit bits cleared", 32'(v[ND-1:0] & mask), 0);
      for (int d = 0; d < ND; d++)
         chk(mask[d] ? "R5 R6 live ratio" : "R9 other live unchanged",
             32'(live_of(d)), 32'(m_live[d]));
   endtask

   task automatic tick_count(int d, int periods);
      int n = 0;
      int len = periods * int'(m_live[d]);
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         if (div_tick[d]) n++;
      end
      chk("R10 tick rate", 32'(n), 32'(periods));
   endtask

   initial begin
      #(4 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [XW-1:0] v;
      void'($urandom(32'd4711));
      for (int d = 0; d < ND; d++) begin m_stage[d] = 1; m_live[d] = 1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int d = 0; d < ND; d++) begin
         chk("R1 live reset", 32'(live_of(d)), 1);
         rd(d, v);
         chk("R1 stage reset", 32'(v), 1);
      end
      chk("R1 busy reset", 32'(div_busy), 0);
      rd(SEQ_A, v);  chk("R1 commit reset", 32'(v), 0);
      rd(BUSY_A, v); chk("R1 busy reg reset", 32'(v), 0);

      // R2, R11: staging alone does nothing
      stage(0, 8'd5);
      repeat (10) @(negedge clk);
      chk("R2 live untouched", 32'(live_of(0)), 1);
      chk("R2 not busy", 32'(div_busy[0]), 0);
      rd(0, v); chk("R11 stage readback", 32'(v), 5);

      commit(4'b0001);
      tick_count(0, 8);

      // R6, R11: zero ratio
      stage(1, 8'd0);
      rd(1, v); chk("R11 zero readback", 32'(v), 0);
      commit(4'b0010);
      chk("R6 zero becomes one", 32'(live_of(1)), 1);

      // R3: zero bits and busy register writes are ignored
      stage(3, 8'd7);
      wr(SEQ_A, '0);
      wr(BUSY_A, XW'(4'hF));
      repeat (4) @(negedge clk);
      chk("R3 no commit from zeros", 32'(div_busy), 0);
      rd(SEQ_A, v); chk("R3 commit reg still 0", 32'(v), 0);
      chk("R3 live3 unchanged", 32'(live_of(3)), 1);

      // R8: changes during a commit in progress
      stage(2, 8'd12);
      commit(4'b0100);
      stage(2, 8'd9);
      wr(SEQ_A, XW'(4'b0100));
      stage(2, 8'd3);
      wr(SEQ_A, XW'(4'b0100));
      wait_idle(2, 20, "R8 first commit finishes");
      chk("R8 captured value used", 32'(live_of(2)), 9);
      repeat (20) @(negedge clk);
      chk("R8 late commit bit ignored", 32'(live_of(2)), 9);
      chk("R8 no busy afterwards", 32'(div_busy[2]), 0);
      m_live[2] = 9;
      commit(4'b0100);
      chk("R8 later commit applies", 32'(live_of(2)), 3);

      // R9: several domains at once
      stage(0, 8'd3);
      stage(1, 8'd4);
      stage(3, 8'd6);
      commit(4'b1011);
      tick_count(3, 6);
      tick_count(1, 5);

      // random staged updates
      for (int it = 0; it < 24; it++) begin
         int d = int'($urandom % ND);
         logic [DW-1:0] nv = DW'($urandom % 20);
         stage(d, nv);
         rd(d, v); chk("R11 random readback", 32'(v), 32'(nv));
         commit(ND'(1) << d);
      end
      tick_count(0, 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule